// File: doc/BRIEF.md
# ADC scan start trigger selector

This block decides when an analog-to-digital scan begins and which input group it serves. A 16-bit trigger-select register holds two 6-bit source codes. One code picks the hardware trigger line for group A, which also serves the single and continuous scan modes. The other code picks the line for group B. Two control inputs gate hardware triggering. The enable bit must be set for any hardware trigger. The external bit then chooses between the synchronous trigger vector and the asynchronous trigger pin.

The block drives one-cycle start pulses to the converter sequencer, one for group A and one for group B. It takes the sequencer's busy flag back in return. Any trigger that arrives while a scan is running, or in the cycle a start pulse is out, is dropped rather than queued.

Group B can only start in group scan mode, and only from a synchronous hardware line. There is one exception. When group A has priority and the continuous-restart bit is set, a group B code of 3Fh makes group B restart its scan by itself each time the converter goes idle. When both groups request a start in the same cycle, group A is started first and the group B start waits until the converter is idle again.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset the register reads 0000h and both start outputs are low.
- R2: A register write keeps bits 13:8 (group A code) and bits 5:0 (group B code). Bits 15:14 and 7:6 always read 0.
- R3: When the group A code is n (1 to SYNC_W), a rising edge on synchronous line n-1 makes startA high for exactly one cycle. The trigger passes one synchronising register first, so startA rises on the second clock edge after the line rises. Holding the line high gives no further pulse.
- R4: Synchronous triggers are accepted only when trgEn=1 and extTrg=0. With trgEn=0, or with extTrg=1, they have no effect.
- R5: In single (scanMode=0) or continuous (scanMode=1) mode, with trgEn=1 and extTrg=1, a falling edge on asyncTrigN makes startA pulse on the third clock edge after the fall. With extTrg=0 the pin has no effect.
- R6: In single or continuous mode, swStart makes startA pulse on the next clock edge, whatever the values of trgEn, extTrg and the group A code.
- R7: In group mode (scanMode=2) and double-trigger mode (scanMode=3), neither swStart nor asyncTrigN starts a scan.
- R8: In group mode, with trgEn=1 and extTrg=0, a rising edge on the line selected by the group B code pulses startB on the second clock edge. In any other mode the group B code is ignored. A group B code of 0 never starts group B.
- R9: A trigger that arrives while busy is high, or in a cycle where a start output is high, is dropped. It does not produce a start later.
- R10: If group A and group B requests arrive in the same cycle, only startA pulses. The group B start is held while busy is high and pulses on the first clock edge after busy falls.
- R11: In group mode with gaPriority=1, gbContRestart=1, trgEn=1 and a group B code of 3Fh, startB pulses on the first clock edge on which the converter is idle. It does so again after each scan ends. Without these conditions, code 3Fh never starts group B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Write strobe for the trigger-select register |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read value |
| trgEn | input | 1 | Hardware trigger enable |
| extTrg | input | 1 | 1 selects the asynchronous pin, 0 selects the synchronous lines |
| syncTrig | input | SYNC_W | Synchronous trigger lines; code n selects bit n-1 |
| asyncTrigN | input | 1 | Asynchronous trigger pin, active on its falling edge |
| swStart | input | 1 | Software start request |
| scanMode | input | 2 | 0 single, 1 continuous, 2 group, 3 double-trigger |
| gaPriority | input | 1 | Group A has priority in group mode |
| gbContRestart | input | 1 | Group B restarts continuously |
| busy | input | 1 | Converter sequencer is scanning |
| startA | output | 1 | One-cycle start pulse for group A |
| startB | output | 1 | One-cycle start pulse for group B |

## Verification
The hardest case to reach from the ports is a held group B start. Both groups must request in the very same cycle. The bench gets there by wiring the group A and group B codes to two lines and raising both lines on one edge. It then holds busy high for several cycles to show that startB stays quiet, and drops busy to check that the deferred pulse follows one edge later. The continuous restart loop is reached in a similar way: the bench acts as the sequencer and raises and lowers busy around each startB pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SEL_W = 6;
  localparam logic [SEL_W-1:0] SEL_NONE = '1;
  localparam logic [15:0] REG_MASK = 16'h3F3F;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_CONT   = 2'd1,
    MODE_GROUP  = 2'd2,
    MODE_DOUBLE = 2'd3
  } scanMode_e;

  // control -> datapath: which start flop to set this cycle
  typedef struct packed {
    logic issueA;
    logic issueB;
  } startStrobe_t;

  // datapath -> control: qualified trigger events
  typedef struct packed {
    logic syncEdgeA;
    logic syncEdgeB;
    logic asyncFall;
    logic selBNone;
  } trigEvent_t;
endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_W = 62
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic [SYNC_W-1:0] syncTrig,
  input  logic              asyncTrigN,
  input  startStrobe_t      strobe,
  output trigEvent_t        evt,
  output logic              startA,
  output logic              startB
);
  localparam int ASYNC_STAGES = 3;

  logic [15:0]             regQ;
  logic [SEL_W-1:0]        selA;
  logic [SEL_W-1:0]        selB;
  logic [SYNC_W-1:0]       trigQ;
  logic [SYNC_W-1:0]       trigQQ;
  logic [SYNC_W-1:0]       edgeVec;
  logic [ASYNC_STAGES-1:0] asyncSync;

  function automatic logic pickEdge(input logic [SYNC_W-1:0] edges,
                                    input logic [SEL_W-1:0] sel);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < SYNC_W; i++) begin
      if (int'(sel) == i + 1) hit = edges[i];
    end
    return hit;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= '0;
    else if (regWrEn) regQ <= regWrData & REG_MASK;
  end

  assign regRdData = regQ;
  assign selA = regQ[13:8];
  assign selB = regQ[5:0];

  // synchronising stage for the timer-domain lines, then edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigQ  <= '0;
      trigQQ <= '0;
    end else begin
      trigQ  <= syncTrig;
      trigQQ <= trigQ;
    end
  end

  assign edgeVec = trigQ & ~trigQQ;

  // two-flop synchroniser plus one history flop; pin idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asyncSync <= '1;
    else asyncSync <= {asyncSync[ASYNC_STAGES-2:0], asyncTrigN};
  end

  always_comb begin
    evt.syncEdgeA = pickEdge(edgeVec, selA);
    evt.syncEdgeB = pickEdge(edgeVec, selB);
    evt.asyncFall = asyncSync[ASYNC_STAGES-1] & ~asyncSync[ASYNC_STAGES-2];
    evt.selBNone  = (selB == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startA <= 1'b0;
      startB <= 1'b0;
    end else begin
      startA <= strobe.issueA;
      startB <= strobe.issueB;
    end
  end

  a_r2_write_mask: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == ($past(regWrData) & 16'h3F3F)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    startA |=> !startA);

  a_r10_one_group: assert property (@(posedge clk) disable iff (!rstN)
    !(startA && startB));
endmodule

// File: rtl/adc_trig_ctl.sv
module adc_trig_ctl
  import adc_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  trigEvent_t   evt,
  input  logic         swStart,
  input  logic         trgEn,
  input  logic         extTrg,
  input  logic [1:0]   scanMode,
  input  logic         gaPriority,
  input  logic         gbContRestart,
  input  logic         busy,
  input  logic         startA,
  input  logic         startB,
  output startStrobe_t strobe
);
  scanMode_e mode;
  logic scanActive;
  logic syncOk;
  logic asyncOk;
  logic swAsyncAllowed;
  logic isGroup;
  logic contB;
  logic reqA;
  logic reqB;
  logic pendB;

  assign mode           = scanMode_e'(scanMode);
  assign scanActive     = busy | startA | startB;
  assign syncOk         = trgEn & ~extTrg;
  assign asyncOk        = trgEn & extTrg;
  assign swAsyncAllowed = (mode == MODE_SINGLE) || (mode == MODE_CONT);
  assign isGroup        = (mode == MODE_GROUP);
  assign contB          = isGroup & gaPriority & gbContRestart & trgEn & evt.selBNone;

  assign reqA = (evt.syncEdgeA & syncOk)
              | (swAsyncAllowed & (swStart | (evt.asyncFall & asyncOk)));
  assign reqB = isGroup & ((evt.syncEdgeB & syncOk) | contB);

  always_comb begin
    strobe.issueA = ~scanActive & reqA;
    strobe.issueB = ~scanActive & ~reqA & (reqB | pendB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendB <= 1'b0;
    else if (!isGroup) pendB <= 1'b0;
    else if (strobe.issueB) pendB <= 1'b0;
    else if (!scanActive && reqA && reqB) pendB <= 1'b1;
  end

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.issueA || strobe.issueB));

  a_r8_b_group_only: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueB |-> (mode == MODE_GROUP));

  a_r7_sw_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (swStart && !swAsyncAllowed && !(evt.syncEdgeA && syncOk)) |-> !strobe.issueA);

  a_r10_pend_a_first: assert property (@(posedge clk) disable iff (!rstN)
    (!scanActive && reqA && reqB) |=> (pendB && startA && !startB));
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
#(
  parameter int SYNC_W = 62
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              trgEn,
  input  logic              extTrg,
  input  logic [SYNC_W-1:0] syncTrig,
  input  logic              asyncTrigN,
  input  logic              swStart,
  input  logic [1:0]        scanMode,
  input  logic              gaPriority,
  input  logic              gbContRestart,
  input  logic              busy,
  output logic              startA,
  output logic              startB
);
  startStrobe_t strobe;
  trigEvent_t   evt;

  adc_trig_dp #(.SYNC_W(SYNC_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .syncTrig(syncTrig), .asyncTrigN(asyncTrigN),
    .strobe(strobe), .evt(evt),
    .startA(startA), .startB(startB)
  );

  adc_trig_ctl ctl_i (
    .clk(clk), .rstN(rstN), .evt(evt),
    .swStart(swStart), .trgEn(trgEn), .extTrg(extTrg),
    .scanMode(scanMode), .gaPriority(gaPriority),
    .gbContRestart(gbContRestart), .busy(busy),
    .startA(startA), .startB(startB), .strobe(strobe)
  );
endmodule

// File: tb/adc_trig_sel_tb_top.sv
module adc_trig_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_W = 62;

  logic clk = 0;
  logic rstN = 0;
  logic regWrEn = 0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic trgEn = 0, extTrg = 0;
  logic [SYNC_W-1:0] syncTrig = '0;
  logic asyncTrigN = 1;
  logic swStart = 0;
  logic [1:0] scanMode = 0;
  logic gaPriority = 0, gbContRestart = 0, busy = 0;
  logic startA, startB;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_sel #(.SYNC_W(SYNC_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .trgEn(trgEn), .extTrg(extTrg),
    .syncTrig(syncTrig), .asyncTrigN(asyncTrigN), .swStart(swStart),
    .scanMode(scanMode), .gaPriority(gaPriority),
    .gbContRestart(gbContRestart), .busy(busy),
    .startA(startA), .startB(startB)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [15:0] v);
    regWrEn = 1; regWrData = v;
    tick(1);
    regWrEn = 0;
  endtask

  task automatic countStarts(input int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      ca += int'(startA);
      cb += int'(startB);
    end
  endtask

  task automatic idle();
    syncTrig = '0; asyncTrigN = 1; swStart = 0; busy = 0;
    gaPriority = 0; gbContRestart = 0;
    tick(4);
  endtask

  task automatic testReset();
    check(regRdData == 16'h0, "R1 reg", regRdData, 0);
    check(!startA && !startB, "R1 starts", {startA, startB}, 0);
  endtask

  task automatic testRegister();
    writeReg(16'hFFFF);
    check(regRdData == 16'h3F3F, "R2 mask", regRdData, 16'h3F3F);
    writeReg(16'h1A05);
    check(regRdData == 16'h1A05, "R2 fields", regRdData, 16'h1A05);
  endtask

  task automatic testSyncA();
    int ca, cb;
    writeReg(16'h0500); scanMode = 0; trgEn = 1; extTrg = 0;
    syncTrig[4] = 1;
    tick(1);
    check(startA == 0, "R3 latency early", startA, 0);
    tick(1);
    check(startA == 1, "R3 pulse", startA, 1);
    countStarts(5, ca, cb);
    check(ca == 0, "R3 one pulse while held", ca, 0);
    idle();
  endtask

  task automatic testSyncGate();
    int ca, cb;
    writeReg(16'h0500); scanMode = 0;
    trgEn = 0; extTrg = 0; syncTrig[4] = 1;
    countStarts(6, ca, cb);
    check(ca == 0, "R4 trgEn=0", ca, 0);
    idle();
    trgEn = 1; extTrg = 1; syncTrig[4] = 1;
    countStarts(6, ca, cb);
    check(ca == 0, "R4 extTrg=1", ca, 0);
    idle();
  endtask

  task automatic testAsync();
    int ca, cb;
    writeReg(16'h0000); scanMode = 0; trgEn = 1; extTrg = 1;
    asyncTrigN = 0;
    tick(2);
    check(startA == 0, "R5 latency early", startA, 0);
    tick(1);
    check(startA == 1, "R5 async pulse", startA, 1);
    idle();
    extTrg = 0; asyncTrigN = 0;
    countStarts(6, ca, cb);
    check(ca == 0, "R5 async ignored extTrg=0", ca, 0);
    idle();
  endtask

  task automatic testSoftware();
    writeReg(16'h0000); trgEn = 0; extTrg = 0;
    for (int m = 0; m < 2; m++) begin
      scanMode = 2'(m);
      swStart = 1;
      tick(1);
      swStart = 0;
      check(startA == 1, "R6 sw start", startA, 1);
      tick(1);
      check(startA == 0, "R6 sw one cycle", startA, 0);
      idle();
    end
  endtask

  task automatic testSwBlocked();
    int ca, cb;
    writeReg(16'h0000); trgEn = 1; extTrg = 1;
    for (int m = 2; m < 4; m++) begin
      scanMode = 2'(m);
      swStart = 1; tick(1); swStart = 0;
      asyncTrigN = 0;
      countStarts(6, ca, cb);
      check(ca == 0 && cb == 0, "R7 sw/async blocked", ca + cb, 0);
      idle();
    end
  endtask

  task automatic testGroupB();
    int ca, cb;
    writeReg(16'h0003); scanMode = 2; trgEn = 1; extTrg = 0;
    syncTrig[2] = 1;
    tick(2);
    check(startB == 1 && startA == 0, "R8 group B pulse", {startA, startB}, 1);
    idle();
    scanMode = 0; syncTrig[2] = 1;
    countStarts(6, ca, cb);
    check(cb == 0 && ca == 0, "R8 B ignored outside group", {ca[3:0], cb[3:0]}, 0);
    idle();
    writeReg(16'h0000); scanMode = 2; syncTrig = '1;
    countStarts(6, ca, cb);
    check(cb == 0 && ca == 0, "R8 code 0 never starts", {ca[3:0], cb[3:0]}, 0);
    idle();
  endtask

  task automatic testBusyDrop();
    int ca, cb;
    writeReg(16'h0500); scanMode = 0; trgEn = 1; extTrg = 0;
    busy = 1; syncTrig[4] = 1;
    countStarts(4, ca, cb);
    busy = 0;
    check(ca == 0, "R9 none while busy", ca, 0);
    countStarts(5, ca, cb);
    check(ca == 0, "R9 dropped not deferred", ca, 0);
    idle();
  endtask

  task automatic testCollision();
    writeReg(16'h0503); scanMode = 2; trgEn = 1; extTrg = 0;
    syncTrig[4] = 1; syncTrig[2] = 1;
    tick(2);
    check(startA == 1 && startB == 0, "R10 A wins", {startA, startB}, 2);
    busy = 1;
    tick(4);
    check(startB == 0, "R10 B held while busy", startB, 0);
    busy = 0;
    tick(1);
    check(startB == 1, "R10 B after busy", startB, 1);
    tick(1);
    check(startB == 0, "R10 B one pulse", startB, 0);
    idle();
  endtask

  task automatic testContRestart();
    int ca, cb;
    writeReg(16'h003F); scanMode = 2; trgEn = 1; extTrg = 0;
    gaPriority = 1; gbContRestart = 1;
    tick(1);
    check(startB == 1, "R11 first restart", startB, 1);
    busy = 1;
    tick(3);
    check(startB == 0, "R11 quiet while busy", startB, 0);
    busy = 0;
    tick(1);
    check(startB == 1 && startA == 0, "R11 restart after scan", {startA, startB}, 1);
    busy = 1; gbContRestart = 0;
    tick(2);
    busy = 0;
    countStarts(6, ca, cb);
    check(cb == 0, "R11 3Fh alone never starts", cb, 0);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    testReset();
    rstN = 1;
    tick(2);
    testReset();
    testRegister();
    testSyncA();
    testSyncGate();
    testAsync();
    testSoftware();
    testSwBlocked();
    testGroupB();
    testBusyDrop();
    testCollision();
    testContRestart();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule